// File: doc/BRIEF.md
# Switch-to-MIDI Control Change Sender

This block turns a two-position speed selector into MIDI traffic. It watches two active-low switch inputs and decodes them into one of three speed modes: slow, stop or fast. When the decoded mode differs from the one it last reported, it waits a settling interval and decodes the switches again. It reports the change only if the second decode still differs from the stored mode. A report is a three-byte Control Change message, sent on an asynchronous serial line at the MIDI bit rate and clocked from a 1 MHz system clock.

After reset the block stays silent for a long start-up interval, with the line idle high. It then polls the switches about once per pause interval. The stored mode starts as stop, so switches that are released at power-up produce no traffic. All intervals are parameters counted in clock cycles, so a bench can shorten them.

Top module: `midi_cc_sender`

## Requirements
- R1: Each serial bit lasts CLKS_PER_BIT clock cycles. The default of 32 cycles at 1 MHz gives 31,250 bit/s.
- R2: Every byte is framed as one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity bit. The line is high whenever no frame is in progress.
- R3: A message consists of three bytes in this order: 0xB4 (Control Change on channel 5), 85 (0x55), then the mode value.
- R4: The decode maps the switch inputs to a mode and value as follows. `sw_a_n` and `sw_b_n` both high gives STOP (64). Only `sw_b_n` low gives SLOW (63). Only `sw_a_n` low gives FAST (65). Both low gives STOP (64).
- R5: A decode that differs from the stored mode starts a wait of SETTLE_CYCLES. A message is sent, and the stored mode updated, only if the decode taken after that wait still differs from the stored mode. The value sent is the one from the second decode. A change that reverts within the wait sends nothing.
- R6: For HOLDOFF_CYCLES after reset the line stays high and nothing is sent, whatever the switches show.
- R7: The stored mode is STOP after reset, so switches held released through start-up produce no message.
- R8: The three bytes of a message follow each other with no gap. Their start edges are exactly 10 bit periods apart.
- R9: `busy` rises in the same cycle as the first start bit and falls when the last stop bit ends, 30 bit periods later.
- R10: A steady switch position whose decode equals the stored mode produces no message, including a different raw input that decodes to the same mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 1 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_a_n | input | 1 | First switch, active low, asynchronous |
| sw_b_n | input | 1 | Second switch, active low, asynchronous |
| midi_tx | output | 1 | Serial MIDI output, idle high |
| busy | output | 1 | High while a message is on the line |

## Verification
The hardest case to reach is a change whose second decode differs from both the first decode and the stored mode. The switch must move once more after a poll has seen the first change but before the settling wait ends, and the poll phase is not visible at the ports. The bench holds the first new position for slightly longer than one poll period, which guarantees that some poll has seen it. It then moves to a third position well before any settling wait that began in that window can end, and expects the third position's value. Short glitches that revert inside the settling window, and inputs that decode to the stored mode, are checked to produce no traffic.

// File: rtl/midi_cc_pkg.sv
// Shared types and constants for the switch-to-MIDI sender.
// Assumes the mode encoding below is used only inside this block.
package midi_cc_pkg;

    typedef enum logic [1:0] {
        SPD_STOP = 2'd0,
        SPD_SLOW = 2'd1,
        SPD_FAST = 2'd2
    } speed_t;

    typedef enum logic [2:0] {
        SQ_HOLDOFF,
        SQ_POLL,
        SQ_SETTLE,
        SQ_SEND,
        SQ_PAUSE
    } seq_state_t;

    localparam logic [7:0] CC_STATUS_BYTE = 8'hB4;
    localparam logic [7:0] CC_NUMBER_BYTE = 8'd85;
    localparam int         MSG_BYTES      = 3;

    // Value byte carried in the message for each mode.
    function automatic logic [7:0] speed_value(speed_t m);
        case (m)
            SPD_SLOW: speed_value = 8'd63;
            SPD_FAST: speed_value = 8'd65;
            default:  speed_value = 8'd64;
        endcase
    endfunction

endpackage

// File: rtl/switch_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous active-low inputs.
// Assumes released (high) is the safe value, so the stages reset to ones.
module switch_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/speed_decode.sv
// Maps the two synchronised active-low switches to a speed mode.
// Assumes both pressed is not a legal position and treats it as stop.
module speed_decode
    import midi_cc_pkg::*;
(
    input  logic   sw_a_n,
    input  logic   sw_b_n,
    output speed_t mode
);

    // Pure combinational decode of the switch pair.
    always_comb begin
        case ({sw_a_n, sw_b_n})
            2'b10:   mode = SPD_SLOW;
            2'b01:   mode = SPD_FAST;
            default: mode = SPD_STOP;
        endcase
    end

endmodule

// File: rtl/serial_tx8n1.sv
// Asynchronous 8N1 transmitter, LSB first, line idle high.
// A byte can be accepted on the last cycle of the previous stop bit,
// so consecutive bytes leave with no gap. Assumes CLKS_PER_BIT >= 2.
module serial_tx8n1 #(
    parameter int CLKS_PER_BIT = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] data,
    output logic       line,
    output logic       ready,
    output logic       active
);

    localparam int DW         = $clog2(CLKS_PER_BIT);
    localparam int FRAME_BITS = 10;
    localparam int BW         = $clog2(FRAME_BITS);

    logic [DW-1:0] div_q;
    logic [BW-1:0] bit_q;
    logic [8:0]    shift_q;
    logic          line_q;
    logic          act_q;
    logic          tick;
    logic          last_tick;

    assign tick      = (div_q == DW'(CLKS_PER_BIT - 1));
    assign last_tick = act_q && tick && (bit_q == BW'(FRAME_BITS - 1));
    assign ready     = !act_q || last_tick;
    assign line      = line_q;
    assign active    = act_q;

    // Frame engine: start bit on load, one bit per CLKS_PER_BIT cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            bit_q   <= '0;
            shift_q <= '1;
            line_q  <= 1'b1;
            act_q   <= 1'b0;
        end else if (load && ready) begin
            line_q  <= 1'b0;
            shift_q <= {1'b1, data};
            div_q   <= '0;
            bit_q   <= '0;
            act_q   <= 1'b1;
        end else if (act_q) begin
            if (tick) begin
                div_q <= '0;
                if (bit_q == BW'(FRAME_BITS - 1)) begin
                    act_q <= 1'b0;
                end else begin
                    line_q  <= shift_q[0];
                    shift_q <= {1'b1, shift_q[8:1]};
                    bit_q   <= bit_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cc_sequencer.sv
// Start-up hold-off, polling, settle-and-confirm and byte sequencing.
// Assumes the mode input is already synchronised. It holds the last
// reported mode and feeds the three message bytes to the transmitter.
module cc_sequencer
    import midi_cc_pkg::*;
#(
    parameter int HOLDOFF_CYCLES = 5_000_000,
    parameter int SETTLE_CYCLES  = 20_000,
    parameter int POLL_CYCLES    = 20_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  speed_t     mode_now,
    input  logic       tx_ready,
    output logic       byte_load,
    output logic [7:0] byte_data,
    output logic       holdoff,
    output logic [1:0] stored_mode
);

    localparam int MAX_A = (HOLDOFF_CYCLES > SETTLE_CYCLES) ? HOLDOFF_CYCLES : SETTLE_CYCLES;
    localparam int MAX_C = (MAX_A > POLL_CYCLES) ? MAX_A : POLL_CYCLES;
    localparam int CW    = $clog2(MAX_C + 1);
    localparam int IW    = $clog2(MSG_BYTES);

    seq_state_t    st_q;
    logic [CW-1:0] cnt_q;
    speed_t        stored_q;
    logic [IW-1:0] idx_q;

    assign holdoff     = (st_q == SQ_HOLDOFF);
    assign stored_mode = stored_q;
    assign byte_load   = (st_q == SQ_SEND) && tx_ready;

    // Select the byte of the message being handed to the transmitter.
    always_comb begin
        case (idx_q)
            IW'(0):  byte_data = CC_STATUS_BYTE;
            IW'(1):  byte_data = CC_NUMBER_BYTE;
            default: byte_data = speed_value(stored_q);
        endcase
    end

    // Control sequence: hold off, poll, confirm after settling, send, pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_HOLDOFF;
            cnt_q    <= '0;
            stored_q <= SPD_STOP;
            idx_q    <= '0;
        end else begin
            case (st_q)
                SQ_HOLDOFF: begin
                    if (cnt_q == CW'(HOLDOFF_CYCLES - 1)) begin
                        cnt_q <= '0;
                        st_q  <= SQ_POLL;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_POLL: begin
                    cnt_q <= '0;
                    st_q  <= (mode_now != stored_q) ? SQ_SETTLE : SQ_PAUSE;
                end
                SQ_SETTLE: begin
                    if (cnt_q == CW'(SETTLE_CYCLES - 1)) begin
                        cnt_q <= '0;
                        if (mode_now != stored_q) begin
                            stored_q <= mode_now;
                            idx_q    <= '0;
                            st_q     <= SQ_SEND;
                        end else begin
                            st_q <= SQ_PAUSE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_SEND: begin
                    if (tx_ready) begin
                        if (idx_q == IW'(MSG_BYTES - 1)) begin
                            cnt_q <= '0;
                            st_q  <= SQ_PAUSE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                SQ_PAUSE: begin
                    if (cnt_q == CW'(POLL_CYCLES - 1)) begin
                        cnt_q <= '0;
                        st_q  <= SQ_POLL;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= SQ_HOLDOFF;
            endcase
        end
    end

endmodule

// File: rtl/midi_cc_sender.sv
// Top level: synchronises the switches, decodes the mode, confirms changes
// and sends a Control Change message per confirmed change. Assumes clk is
// the 1 MHz bit-rate reference; all intervals are in clk cycles.
module midi_cc_sender
    import midi_cc_pkg::*;
#(
    parameter int CLKS_PER_BIT   = 32,
    parameter int HOLDOFF_CYCLES = 5_000_000,
    parameter int SETTLE_CYCLES  = 20_000,
    parameter int POLL_CYCLES    = 20_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_a_n,
    input  logic sw_b_n,
    output logic midi_tx,
    output logic busy
);

    logic [1:0] sw_sync;
    speed_t     mode_now;
    logic       tx_ready;
    logic       byte_load;
    logic [7:0] byte_data;
    logic       holdoff;
    logic [1:0] stored_mode;

    switch_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sw_a_n, sw_b_n}),
        .sync_out (sw_sync)
    );

    speed_decode u_dec (
        .sw_a_n (sw_sync[1]),
        .sw_b_n (sw_sync[0]),
        .mode   (mode_now)
    );

    cc_sequencer #(
        .HOLDOFF_CYCLES (HOLDOFF_CYCLES),
        .SETTLE_CYCLES  (SETTLE_CYCLES),
        .POLL_CYCLES    (POLL_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_now    (mode_now),
        .tx_ready    (tx_ready),
        .byte_load   (byte_load),
        .byte_data   (byte_data),
        .holdoff     (holdoff),
        .stored_mode (stored_mode)
    );

    serial_tx8n1 #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (byte_load),
        .data   (byte_data),
        .line   (midi_tx),
        .ready  (tx_ready),
        .active (busy)
    );

endmodule

// File: rtl/midi_cc_sender_chk.sv
// Protocol checker for midi_cc_sender, attached by bind below.
module midi_cc_sender_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       midi_tx,
    input logic       busy,
    input logic       holdoff,
    input logic [1:0] stored_mode
);

    AST_LINE_HIGH_IN_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |-> (midi_tx && !busy)); // R6

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> midi_tx); // R2

    AST_START_AT_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !midi_tx); // R9

    AST_STOP_BEFORE_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(midi_tx)); // R2

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stored_mode != 2'b11); // R4

    AST_CHANGE_STARTS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stored_mode) |=> busy); // R5

endmodule

bind midi_cc_sender midi_cc_sender_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .midi_tx     (midi_tx),
    .busy        (busy),
    .holdoff     (holdoff),
    .stored_mode (stored_mode)
);

// File: tb/midi_cc_sender_test.sv
`timescale 1ns/1ps
// Sweep bench: shortened intervals, all switch transitions, serial decode.
module midi_cc_sender_test;

    localparam int DIV     = 8;
    localparam int HOLD    = 300;
    localparam int SETTLE  = 50;
    localparam int POLL    = 40;
    localparam int WAITMSG = 600;
    localparam realtime TCLK = 5.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_a_n = 1'b1;
    logic sw_b_n = 1'b1;
    logic midi_tx;
    logic busy;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] rx_buf [0:255];
    int rx_n = 0;
    logic [7:0] exp_val;

    always #2.5 clk = ~clk;

    midi_cc_sender #(
        .CLKS_PER_BIT   (DIV),
        .HOLDOFF_CYCLES (HOLD),
        .SETTLE_CYCLES  (SETTLE),
        .POLL_CYCLES    (POLL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sw_a_n(sw_a_n), .sw_b_n(sw_b_n),
        .midi_tx(midi_tx), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] model_val(input logic a, input logic b);
        if (a && !b) return 8'd63;
        if (!a && b) return 8'd65;
        return 8'd64;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Serial receiver: mid-bit sampling, stop-bit and spacing checks (R1 R2 R8).
    initial begin
        realtime last_start;
        last_start = -1.0e9;
        forever begin
            logic [7:0] b;
            realtime t0;
            @(negedge midi_tx);
            t0 = $realtime;
            if (t0 - last_start < 20 * DIV * TCLK)
                check((t0 - last_start) == 10 * DIV * TCLK, "R8 R1 byte spacing",
                      longint'(t0 - last_start), longint'(10 * DIV * TCLK));
            last_start = t0;
            repeat (DIV / 2) @(posedge clk);
            #1;
            check(midi_tx == 1'b0, "R2 start bit", midi_tx, 0);
            for (int i = 0; i < 8; i++) begin
                repeat (DIV) @(posedge clk);
                #1;
                b[i] = midi_tx;
            end
            repeat (DIV) @(posedge clk);
            #1;
            check(midi_tx == 1'b1, "R2 stop bit", midi_tx, 1);
            if (rx_n < 256) rx_buf[rx_n] = b;
            rx_n++;
        end
    end

    // Busy window length: 30 bit periods from first start bit (R9).
    initial begin
        forever begin
            realtime tr;
            @(posedge busy);
            tr = $realtime;
            @(negedge busy);
            check(($realtime - tr) == 30 * DIV * TCLK, "R9 busy length",
                  longint'($realtime - tr), longint'(30 * DIV * TCLK));
        end
    end

    task automatic expect_msg(input logic [7:0] val, input string req);
        int base;
        base = rx_n;
        cycles(WAITMSG);
        check(rx_n == base + 3, req, rx_n - base, 3);
        if (rx_n == base + 3) begin
            check(rx_buf[base] == 8'hB4, "R3 status byte", rx_buf[base], 8'hB4);
            check(rx_buf[base+1] == 8'd85, "R3 controller byte", rx_buf[base+1], 85);
            check(rx_buf[base+2] == val, {req, " value"}, rx_buf[base+2], val);
        end
    endtask

    task automatic expect_none(input string req);
        int base;
        base = rx_n;
        cycles(WAITMSG);
        check(rx_n == base, req, rx_n - base, 0);
    endtask

    initial begin
        #(150000 * TCLK);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] stored;
        int base;
        // Reset state and R7: released switches, no start-up message.
        cycles(5);
        check(midi_tx == 1'b1, "R2 reset line high", midi_tx, 1);
        check(busy == 1'b0, "R9 reset busy low", busy, 0);
        rst_n = 1'b1;
        expect_none("R7 released start-up");
        cycles(HOLD);

        // R6: hold-off with FAST pressed through reset.
        rst_n = 1'b0;
        sw_a_n = 1'b0;
        cycles(5);
        base = rx_n;
        rst_n = 1'b1;
        cycles(HOLD - 10);
        check(rx_n == base, "R6 no bytes during hold-off", rx_n - base, 0);
        check(midi_tx == 1'b1 && busy == 1'b0, "R6 line idle during hold-off", midi_tx, 1);
        expect_msg(8'd65, "R6 R4 message after hold-off");
        stored = 8'd65;

        // Exhaustive sweep of switch positions and transitions (R4 R10).
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [1:0] p;
                    p = (k == 0) ? 2'(i) : 2'(j);
                    sw_a_n = p[1];
                    sw_b_n = p[0];
                    exp_val = model_val(p[1], p[0]);
                    if (exp_val != stored) expect_msg(exp_val, "R4 decoded change");
                    else expect_none("R10 same mode silent");
                    stored = exp_val;
                end
            end
        end

        // R5: a glitch shorter than the settle window sends nothing.
        sw_a_n = 1'b1; sw_b_n = 1'b1;
        if (stored != 8'd64) expect_msg(8'd64, "R4 back to stop");
        stored = 8'd64;
        for (int g = 0; g < 3; g++) begin
            sw_a_n = 1'b0;
            cycles(10 + 7 * g);
            sw_a_n = 1'b1;
            expect_none("R5 glitch ignored");
        end

        // R5: the value sent is the second decode.
        sw_a_n = 1'b0;
        cycles(POLL + 5);
        sw_a_n = 1'b1;
        sw_b_n = 1'b0;
        expect_msg(8'd63, "R5 second decode sent");
        stored = 8'd63;

        // R5: stored mode updated, so the same position stays silent.
        expect_none("R5 stored updated");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule